// File: doc/BRIEF.md
# Serial-Bus Synthesizer Control Target

This block is an I2C target that loads the control registers of a frequency synthesizer. The bus lines reach it unsynchronised; it resynchronises them against a system clock at least eight times faster than SCL, finds START, STOP and clock edges, and answers by pulling SDA low through an open-drain enable. A two-bit select input sets the low bits of its address, so several such devices can sit on one bus.

A write carries no register address. The data bytes arrive in pairs, and the most significant bit of the first byte in each pair decides what the pair is: a 0 marks a frequency pair that together holds a 15-bit divider word, and a 1 marks a control pair that fills two control bytes. Any number of pairs may follow one address byte. The divider word is loaded only once the whole word has arrived, or when a STOP cuts the pair short. A read returns a status byte that holds a sticky power-on flag and the lock flag. The target repeats that byte for as long as the master acknowledges it.

Top module: `i2c_synth_ctrl`

## Requirements
- R1: The target answers to the 7-bit address {5'b11000, addr_sel_i}. When the address matches, it drives SDA low during the acknowledge clock. When the address does not match, SDA stays released until the next START, and no data byte of that transaction changes any output.
- R2: In a write, every complete data byte is acknowledged by SDA low during its ninth clock.
- R3: A pair whose first byte has bit 7 = 0 is a frequency pair. Bits 6:0 of the first byte become freq_word_o[14:8], and the second byte becomes freq_word_o[7:0].
- R4: A pair whose first byte has bit 7 = 1 is a control pair. The first byte is stored whole in ctrl_c_o and the second in ctrl_d_o, each as soon as that byte completes.
- R5: After a pair completes, the next byte starts a new pair that is decoded the same way, with no new address byte.
- R6: freq_word_o changes only when the second frequency byte completes, or at a STOP that follows a first frequency byte with no second byte. In that case only bits 14:8 are replaced.
- R7: A byte cut short by a STOP changes no output. Bytes completed before it are kept.
- R8: A read sends the status byte MSB first: bit 7 is the power-on flag, bit 6 is lock_i (1 = locked), and bits 5:0 are 0.
- R9: The power-on flag is 1 after reset and after any cycle with por_flag_i high. Only a STOP that ends a read transaction clears it.
- R10: When the master acknowledges a status byte, another status byte follows. When the master does not acknowledge, SDA stays released until the next START.
- R11: A repeated START, even in the middle of a byte, restarts address reception.
- R12: After reset, freq_word_o, ctrl_c_o and ctrl_d_o are 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Low two address bits |
| por_flag_i | input | 1 | Sets the sticky power-on flag |
| lock_i | input | 1 | Synthesizer lock indication |
| freq_word_o | output | 15 | Divider word |
| ctrl_c_o | output | 8 | First control byte |
| ctrl_d_o | output | 8 | Second control byte |

## Verification
A bus line change reaches the edge detector after two synchroniser flops plus one delay flop. A register output therefore moves about three system cycles after the SCL rise that completes a byte, or after the SDA rise of a STOP. The SDA enable moves about three cycles after an SCL fall. The bench holds each SCL level for ten cycles. It samples SDA in the middle of the high phase and compares the outputs with its own model on every falling clock edge. Comparison is paused from the start of a byte until the model has taken that byte, so the three-cycle settling window is never sampled.

// File: rtl/i2c_synth_pkg.sv
package i2c_synth_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s      = scl_sh[SYNC_STAGES-1];
  assign sda_s_o    = sda_sh[SYNC_STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA moving while SCL is steadily high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/i2c_synth_regs.sv
module i2c_synth_regs #(
  parameter int FREQ_W = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [BYTE_W-1:0] ctrl_c_o,
  output logic [BYTE_W-1:0] ctrl_d_o
);
  localparam int HI_W = FREQ_W - BYTE_W;

  logic            second_q, ctrl_pair_q, pend_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q    <= 1'b0;
      ctrl_pair_q <= 1'b0;
      pend_q      <= 1'b0;
      hi_q        <= '0;
      freq_o      <= '0;
      ctrl_c_o    <= '0;
      ctrl_d_o    <= '0;
    end else if (txn_start_i) begin
      second_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (stop_i) begin
      // half-received frequency pair: load the upper part only
      if (pend_q) freq_o <= {hi_q, freq_o[BYTE_W-1:0]};
      pend_q   <= 1'b0;
      second_q <= 1'b0;
    end else if (byte_vld_i) begin
      if (!second_q) begin
        second_q    <= 1'b1;
        ctrl_pair_q <= byte_i[BYTE_W-1];
        if (byte_i[BYTE_W-1]) begin
          ctrl_c_o <= byte_i;
        end else begin
          hi_q   <= byte_i[HI_W-1:0];
          pend_q <= 1'b1;
        end
      end else begin
        second_q <= 1'b0;
        if (ctrl_pair_q) begin
          ctrl_d_o <= byte_i;
        end else begin
          freq_o <= {hi_q, byte_i};
          pend_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_synth_ctrl.sv
module i2c_synth_ctrl
  import i2c_synth_pkg::*;
#(
  parameter int   SEL_W       = 2,
  parameter int   FREQ_W      = 15,
  parameter int   BYTE_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic [BYTE_W-2-SEL_W:0] ADDR_BASE = 5'b11000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic              por_flag_i,
  input  logic              lock_i,
  output logic [FREQ_W-1:0] freq_word_o,
  output logic [BYTE_W-1:0] ctrl_c_o,
  output logic [BYTE_W-1:0] ctrl_d_o
);
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, status, rx_byte;
  logic              oe_q, rw_q, rd_act_q, por_q, mack_q;
  logic              full, last_bit, wr_byte_vld, ignore_st;
  logic [ADDR_W-1:0] my_addr;

  assign rx_byte     = {sh_q[BYTE_W-2:0], sda_s};
  assign full        = (cnt_q == CNT_W'(BYTE_W));
  assign last_bit    = (cnt_q == CNT_W'(BYTE_W - 1));
  assign my_addr     = {ADDR_BASE, addr_sel_i};
  assign wr_byte_vld = (st_q == ST_WDATA) && scl_rise && last_bit;
  assign ignore_st   = (st_q == ST_IGNORE);
  assign sda_oe_o    = oe_q;

  always_comb begin
    status             = '0;
    status[BYTE_W-1]   = por_q;
    status[BYTE_W-2]   = lock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) por_q <= 1'b1;
    else if (por_flag_i) por_q <= 1'b1;
    else if (stop_evt && rd_act_q) por_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
      rd_act_q <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start_evt) begin
      st_q     <= ST_ADDR;
      cnt_q    <= '0;
      oe_q     <= 1'b0;
      rd_act_q <= 1'b0;
    end else if (stop_evt) begin
      st_q     <= ST_IDLE;
      oe_q     <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise && !full) begin
            sh_q  <= rx_byte;
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (scl_fall && full) begin
            if (sh_q[BYTE_W-1:1] == my_addr) begin
              oe_q <= 1'b1;
              rw_q <= sh_q[0];
              st_q <= ST_ADDR_ACK;
            end else begin
              st_q <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= status;
              oe_q     <= ~status[BYTE_W-1];
              rd_act_q <= 1'b1;
              st_q     <= ST_RDATA;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise && !full) begin
            sh_q  <= rx_byte;
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (scl_fall && full) begin
            oe_q <= 1'b1;
            st_q <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (last_bit) begin
              oe_q   <= 1'b0;
              mack_q <= 1'b0;
              st_q   <= ST_RACK;
            end else begin
              tx_q  <= tx_q << 1;
              oe_q  <= ~tx_q[BYTE_W-2];
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (!sda_s) mack_q <= 1'b1;
            else        st_q   <= ST_IGNORE;  // no master ack: act as stopped
          end else if (scl_fall && mack_q) begin
            tx_q  <= status;
            oe_q  <= ~status[BYTE_W-1];
            cnt_q <= '0;
            st_q  <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  i2c_synth_regs #(.FREQ_W(FREQ_W), .BYTE_W(BYTE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .txn_start_i (start_evt),
    .stop_i      (stop_evt),
    .byte_vld_i  (wr_byte_vld),
    .byte_i      (rx_byte),
    .freq_o      (freq_word_o),
    .ctrl_c_o    (ctrl_c_o),
    .ctrl_d_o    (ctrl_d_o)
  );
endmodule

// File: rtl/i2c_synth_ctrl_chk.sv
module i2c_synth_ctrl_chk #(
  parameter int FREQ_W = 15,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_o,
  input logic              scl_fall,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              wr_byte_vld,
  input logic              ignore_st,
  input logic [FREQ_W-1:0] freq_word_o,
  input logic [BYTE_W-1:0] ctrl_c_o,
  input logic [BYTE_W-1:0] ctrl_d_o
);
  p_oe_after_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  p_ignore_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_st |-> !sda_oe_o);

  p_freq_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(freq_word_o) |-> $past(wr_byte_vld || stop_evt));

  p_ctrl_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ctrl_c_o) || !$stable(ctrl_d_o)) |-> $past(wr_byte_vld));

  p_stop_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o);

  p_restart_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_oe_o);
endmodule

bind i2c_synth_ctrl i2c_synth_ctrl_chk #(.FREQ_W(FREQ_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_oe_o    (sda_oe_o),
  .scl_fall    (scl_fall),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .wr_byte_vld (wr_byte_vld),
  .ignore_st   (ignore_st),
  .freq_word_o (freq_word_o),
  .ctrl_c_o    (ctrl_c_o),
  .ctrl_d_o    (ctrl_d_o)
);

// File: tb/i2c_synth_ctrl_tb.sv
module i2c_synth_ctrl_tb_top;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic [1:0] sel = 2'd2;
  logic por_in = 1'b0, lock = 1'b0;
  logic dut_oe;
  logic [14:0] freq;
  logic [7:0] cc, cd;
  wire sda_line = dut_oe ? 1'b0 : m_sda;

  int total = 0, bad = 0;
  bit cmp_en = 0;

  // behavioural model
  logic [14:0] e_freq = '0;
  logic [7:0]  e_c = '0, e_d = '0;
  logic [6:0]  e_hi = '0;
  bit e_wr = 0, e_second = 0, e_ctrl = 0, e_pend = 0, e_por = 1;

  always #5 clk = ~clk;

  i2c_synth_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(dut_oe),
    .addr_sel_i(sel), .por_flag_i(por_in), .lock_i(lock),
    .freq_word_o(freq), .ctrl_c_o(cc), .ctrl_d_o(cd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(freq === e_freq, "R3 freq compare", int'(freq), int'(e_freq));
      chk(cc === e_c && cd === e_d, "R4 ctrl compare", int'({cc, cd}), int'({e_c, e_d}));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; tick(Q);
    scl = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic m_byte(input logic [7:0] b);
    if (!e_wr) return;
    if (!e_second) begin
      e_second = 1; e_ctrl = b[7];
      if (b[7]) e_c = b;
      else begin e_hi = b[6:0]; e_pend = 1; end
    end else begin
      e_second = 0;
      if (e_ctrl) e_d = b;
      else begin e_freq = {e_hi, b}; e_pend = 0; end
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
    e_second = 0; e_pend = 0; e_wr = 0;
  endtask

  task automatic bus_stop(input bit was_read);
    cmp_en = 0;
    m_sda = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
    if (e_pend) e_freq = {e_hi, e_freq[7:0]};
    e_pend = 0; e_second = 0; e_wr = 0;
    if (was_read) e_por = 0;
    cmp_en = 1;
  endtask

  task automatic send(input logic [7:0] b, input bit is_addr, input bit exp_ack, input string tag);
    logic s;
    cmp_en = 0;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    chk((s == 1'b0) == exp_ack, tag, int'(s), int'(!exp_ack));
    if (is_addr) begin
      if (exp_ack && !b[0]) e_wr = 1;
    end else begin
      m_byte(b);
    end
    cmp_en = 1;
  endtask

  task automatic recv(input bit m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!m_ack, s);
  endtask

  task automatic partial(input int n, input logic [7:0] b);
    logic s;
    cmp_en = 0;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
    cmp_en = 1;
  endtask

  initial begin
    logic [7:0] d;
    logic s;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R12 reset state
    chk(freq == 0 && cc == 0 && cd == 0, "R12 reset regs", int'({freq, cc, cd}), 0);
    chk(dut_oe == 0, "R12 sda released", int'(dut_oe), 0);
    cmp_en = 1;

    // R1 R2 R3 R4 R5: paired writes under one address
    bus_start();
    send(8'hC4, 1, 1, "R1 address ack");
    send(8'h12, 0, 1, "R2 ack freq A");
    send(8'h34, 0, 1, "R2 ack freq B");
    chk(freq == 15'h1234, "R3 freq pair", int'(freq), 'h1234);
    send(8'h85, 0, 1, "R2 ack ctrl C");
    chk(cc == 8'h85, "R4 ctrl C", int'(cc), 'h85);
    send(8'h5A, 0, 1, "R2 ack ctrl D");
    chk(cd == 8'h5A, "R4 ctrl D", int'(cd), 'h5A);
    send(8'h7F, 0, 1, "R5 ack third pair A");
    send(8'hFF, 0, 1, "R5 ack third pair B");
    chk(freq == 15'h7FFF, "R5 pair without readdress", int'(freq), 'h7FFF);
    bus_stop(0);

    // R1 mismatch
    bus_start();
    send(8'hC0, 1, 0, "R1 no ack on mismatch");
    send(8'h00, 0, 0, "R1 ignored data no ack");
    send(8'h00, 0, 0, "R1 ignored data no ack");
    chk(freq == 15'h7FFF, "R1 ignored write", int'(freq), 'h7FFF);
    bus_stop(0);

    // R6 lone first frequency byte, committed at STOP
    bus_start();
    send(8'hC4, 1, 1, "R6 address ack");
    send(8'h05, 0, 1, "R6 ack lone A");
    chk(freq == 15'h7FFF, "R6 held before stop", int'(freq), 'h7FFF);
    bus_stop(0);
    chk(freq == 15'h05FF, "R6 upper at stop", int'(freq), 'h05FF);

    // R7 partial byte discarded
    bus_start();
    send(8'hC4, 1, 1, "R7 address ack");
    send(8'h01, 0, 1, "R7 ack A");
    send(8'h02, 0, 1, "R7 ack B");
    partial(3, 8'h60);
    bus_stop(0);
    chk(freq == 15'h0102, "R7 partial freq byte", int'(freq), 'h0102);
    bus_start();
    send(8'hC4, 1, 1, "R7 address ack");
    send(8'h99, 0, 1, "R7 ack C");
    partial(5, 8'hFF);
    bus_stop(0);
    chk(cc == 8'h99 && cd == 8'h5A, "R7 partial ctrl D", int'({cc, cd}), 'h995A);

    // R11 repeated start mid address
    bus_start();
    partial(3, 8'hC0);
    bus_start();
    send(8'hC4, 1, 1, "R11 ack after restart");
    send(8'hA1, 0, 1, "R11 ack C");
    send(8'h3C, 0, 1, "R11 ack D");
    bus_stop(0);
    chk(cc == 8'hA1 && cd == 8'h3C, "R11 write after restart", int'({cc, cd}), 'hA13C);

    // R8 R9 R10 reads
    lock = 1'b1;
    bus_start();
    send(8'hC5, 1, 1, "R8 read address ack");
    recv(1, d);
    chk(d == {e_por, lock, 6'b0}, "R8 status byte", int'(d), int'({e_por, lock, 6'b0}));
    recv(0, d);
    chk(d == 8'hC0, "R10 repeat after master ack", int'(d), 'hC0);
    for (int i = 0; i < 4; i++) begin
      clk_bit(1'b1, s);
      chk(s == 1'b1, "R10 released after nack", int'(s), 1);
    end
    bus_stop(1);
    lock = 1'b0;
    bus_start();
    send(8'hC5, 1, 1, "R9 read address ack");
    recv(0, d);
    chk(d == 8'h00, "R9 flag cleared by read stop", int'(d), 0);
    bus_stop(1);

    por_in = 1'b1; tick(2); por_in = 1'b0; e_por = 1;
    bus_start();
    send(8'hC4, 1, 1, "R9 write address ack");
    send(8'h80, 0, 1, "R9 ack C");
    send(8'h01, 0, 1, "R9 ack D");
    bus_stop(0);
    bus_start();
    send(8'hC5, 1, 1, "R9 read address ack");
    recv(0, d);
    chk(d == 8'h80, "R9 flag survives write stop", int'(d), 'h80);
    bus_stop(1);
    tick(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule